// File: doc/BRIEF.md
# Stack Pointer Unit with Limit and Floor Traps

This block owns the stack pointer of a small 16-bit processor datapath. The stack grows upward: the pointer always names the next free word. A push writes at the pointer and then moves it up one word. A pop moves it down one word and then reads. The block does not hold the stack memory. It drives the address, write strobe, write data and read strobe of an external data RAM port.

Besides single-word push and pop, the block builds two-word frames from a 23-bit program counter. A call frame stores the counter with its upper word zero-padded. An exception frame also packs an 8-bit status byte into that upper word. Every pointer-based access is checked against a programmable upper limit and a fixed lower floor. A failing access is suppressed and reported as a one-cycle trap with a cause bit.

Software can load the pointer and the limit directly. A limit write takes one extra cycle to reach the comparator. Any access presented in the cycle right after a limit write is held back and replayed one cycle later, so that it is checked against the new limit.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the pointer reads 0x0800, `busy` is low, and no RAM strobe or trap is active.
- R2: A push drives `ramWe` with `ramAddr` equal to the pointer, then adds 2 to the pointer. A pop drives `ramRe` with `ramAddr` equal to the pointer minus 2, then subtracts 2 from the pointer.
- R3: Bit 0 of a value written to the pointer or to the limit is stored as 0.
- R4: A push at a pointer equal to the limit completes normally. A push at a pointer above the limit is suppressed, leaves the pointer unchanged and pulses `trapValid` with `trapCause` = 0 (overflow).
- R5: Any access whose address would be below 0x0800 is suppressed, leaves the pointer unchanged and pulses `trapValid` with `trapCause` = 1 (underflow). Underflow takes precedence when overflow also applies.
- R6: A call frame writes PC[15:0] first, then {9'b0, PC[22:16]} at the next address, one word per cycle. The pointer ends 4 higher, and `busy` is high during the second word.
- R7: An exception frame writes PC[15:0] first, then a word with the status byte in bits 15:8, bit 7 = 0 and PC[22:16] in bits 6:0.
- R8: An access requested in the cycle right after a limit write makes no RAM access in that cycle. It is performed in the following cycle with `busy` high, and is checked against the newly written limit.
- R9: Requests presented while `busy` is high are ignored. When several requests arrive together, the priority is exception frame, then call frame, then push, then pop.
- R10: If the first word of a frame traps, the frame is abandoned. No second word is written and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushReq | input | 1 | Single-word push request |
| pushData | input | 16 | Word to push |
| popReq | input | 1 | Single-word pop request |
| callReq | input | 1 | Call-frame push request |
| excReq | input | 1 | Exception-frame push request |
| pcIn | input | 23 | Program counter for frame pushes |
| statusIn | input | 8 | Low status byte for exception frames |
| spWrEn | input | 1 | Direct pointer load |
| spWrData | input | 16 | Value for direct pointer load |
| limWrEn | input | 1 | Limit register write |
| limWrData | input | 16 | Value for limit write |
| ramAddr | output | 16 | Effective address to data RAM |
| ramWe | output | 1 | RAM write strobe |
| ramWdata | output | 16 | RAM write data |
| ramRe | output | 1 | RAM read strobe |
| sp | output | 16 | Current stack pointer |
| busy | output | 1 | Frame second word or deferred access in progress |
| trapValid | output | 1 | Stack-error trap pulse |
| trapCause | output | 1 | 0 = overflow, 1 = underflow |

## Verification
The bench aims at the edges of the two checks. It pushes at exactly the limit and then one word beyond it, which catches an off-by-one comparator that traps one push early or one push late. It pops at the floor, where a floor test on the pointer instead of the decremented address would let a read into the register-mapped region through. It requests a push in the cycle right after lowering the limit. A design that compared against the stale limit would write where it should trap, and one that dropped the deferred request would neither write nor trap. The frame tests check the packing of the upper word, the four-byte pointer advance, that a request during the second word is ignored, and that a frame whose first word traps leaves no second write behind.

// File: rtl/spu_pkg.sv
package spu_pkg;

  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_PUSH = 3'd1,
    K_POP  = 3'd2,
    K_CALL = 3'd3,
    K_EXC  = 3'd4
  } reqKind_t;

  typedef enum logic [1:0] {
    W_DATA   = 2'd0,
    W_PCLO   = 2'd1,
    W_CALLHI = 2'd2,
    W_EXCHI  = 2'd3
  } wordSel_t;

  typedef struct packed {
    logic     accPush;   // perform a write access at the pointer
    logic     accPop;    // perform a read access below the pointer
    logic     fromCap;   // take operands from the captured request
    logic     capture;   // latch request kind and operands
    reqKind_t kind;      // kind being latched
    wordSel_t wordSel;   // which word to drive as write data
  } strobes_t;

  typedef enum logic {
    CAUSE_OVF = 1'b0,
    CAUSE_UND = 1'b1
  } cause_t;

endpackage

// File: rtl/spu_ctrl.sv
module spu_ctrl
  import spu_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     pushReq,
  input  logic     popReq,
  input  logic     callReq,
  input  logic     excReq,
  input  logic     limPend,
  input  logic     accTrap,
  input  reqKind_t capKind,
  output strobes_t st,
  output logic     busy
);

  typedef enum logic [1:0] {S_IDLE, S_REPLAY, S_HI} state_t;

  state_t   state, nxt;
  reqKind_t inKind;

  function automatic logic isFrame(reqKind_t k);
    return (k == K_CALL) || (k == K_EXC);
  endfunction

  // fixed priority: exception, call, push, pop
  always_comb begin
    if (excReq)       inKind = K_EXC;
    else if (callReq) inKind = K_CALL;
    else if (pushReq) inKind = K_PUSH;
    else if (popReq)  inKind = K_POP;
    else              inKind = K_NONE;
  end

  // strobes to the datapath
  always_comb begin
    reqKind_t doKind;
    st      = '0;
    st.kind = inKind;
    doKind  = K_NONE;
    unique case (state)
      S_IDLE: begin
        if (inKind != K_NONE) begin
          if (limPend) begin
            st.capture = 1'b1;
          end else begin
            st.capture = isFrame(inKind);
            doKind     = inKind;
          end
        end
      end
      S_REPLAY: begin
        if (!limPend) begin
          doKind     = capKind;
          st.fromCap = 1'b1;
        end
      end
      S_HI: begin
        if (!limPend) begin
          st.accPush = 1'b1;
          st.fromCap = 1'b1;
          st.wordSel = (capKind == K_CALL) ? W_CALLHI : W_EXCHI;
        end
      end
      default: ;
    endcase
    unique case (doKind)
      K_PUSH: begin st.accPush = 1'b1; st.wordSel = W_DATA; end
      K_POP:  begin st.accPop  = 1'b1; end
      K_CALL,
      K_EXC:  begin st.accPush = 1'b1; st.wordSel = W_PCLO; end
      default: ;
    endcase
  end

  // next state, after the datapath has judged the access
  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE: begin
        if (inKind != K_NONE) begin
          if (limPend)                         nxt = S_REPLAY;
          else if (isFrame(inKind) && !accTrap) nxt = S_HI;
        end
      end
      S_REPLAY: begin
        if (!limPend) nxt = (isFrame(capKind) && !accTrap) ? S_HI : S_IDLE;
      end
      S_HI: begin
        if (!limPend) nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  assign busy = (state != S_IDLE);

  // R6: an untrapped frame start leads to a busy second-word cycle
  assert_frame_goes_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && !limPend && (excReq || callReq) && !accTrap) |=> busy);

  // R10: a trapped frame start returns to idle
  assert_frame_abort_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && !limPend && (excReq || callReq) && accTrap) |=> !busy);

endmodule

// File: rtl/spu_datapath.sv
module spu_datapath
  import spu_pkg::*;
#(
  parameter int              DATA_W     = 16,
  parameter int              PC_W       = 23,
  parameter int              STAT_W     = 8,
  parameter logic [DATA_W-1:0] FLOOR_ADDR = 16'h0800,
  parameter logic [DATA_W-1:0] SP_RESET   = 16'h0800
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          st,
  input  logic [DATA_W-1:0] pushData,
  input  logic [PC_W-1:0]   pcIn,
  input  logic [STAT_W-1:0] statusIn,
  input  logic              spWrEn,
  input  logic [DATA_W-1:0] spWrData,
  input  logic              limWrEn,
  input  logic [DATA_W-1:0] limWrData,
  output logic [DATA_W-1:0] ramAddr,
  output logic              ramWe,
  output logic [DATA_W-1:0] ramWdata,
  output logic              ramRe,
  output logic [DATA_W-1:0] spOut,
  output logic              limPend,
  output logic              accTrap,
  output cause_t            trapCause,
  output reqKind_t          capKind
);

  localparam int HI_W = PC_W - DATA_W;
  localparam logic [DATA_W-1:0] WORD_STEP = DATA_W'(2);
  localparam logic [DATA_W-1:0] ALIGN_MASK = ~DATA_W'(1);
  localparam logic [DATA_W:0]   POP_FLOOR = {1'b0, FLOOR_ADDR} + (DATA_W+1)'(2);

  logic [DATA_W-1:0] spReg, limStage, limReg;
  logic [DATA_W-1:0] capData;
  logic [PC_W-1:0]   capPc;
  logic [STAT_W-1:0] capStat;

  logic [DATA_W-1:0] srcData;
  logic [PC_W-1:0]   srcPc;
  logic [STAT_W-1:0] srcStat;
  logic [DATA_W-1:0] callHi, excHi;
  logic              isOvf, isUnd;

  // operand selection
  assign srcData = st.fromCap ? capData : pushData;
  assign srcPc   = st.fromCap ? capPc   : pcIn;
  assign srcStat = st.fromCap ? capStat : statusIn;

  assign callHi = DATA_W'(srcPc[PC_W-1:DATA_W]);
  assign excHi  = (DATA_W'(srcStat) << (DATA_W - STAT_W)) | DATA_W'(srcPc[PC_W-1:DATA_W]);

  always_comb begin
    unique case (st.wordSel)
      W_DATA:   ramWdata = srcData;
      W_PCLO:   ramWdata = srcPc[DATA_W-1:0];
      W_CALLHI: ramWdata = callHi;
      W_EXCHI:  ramWdata = excHi;
      default:  ramWdata = srcData;
    endcase
  end

  // effective address and checks
  assign ramAddr = st.accPop ? (spReg - WORD_STEP) : spReg;

  assign isOvf = st.accPush && (spReg > limReg);
  assign isUnd = (st.accPush && (spReg < FLOOR_ADDR)) ||
                 (st.accPop  && ({1'b0, spReg} < POP_FLOOR));

  assign accTrap   = isOvf || isUnd;
  assign trapCause = isUnd ? CAUSE_UND : CAUSE_OVF;

  assign ramWe = st.accPush && !accTrap;
  assign ramRe = st.accPop  && !accTrap;

  // pointer
  always_ff @(posedge clk) begin
    if (!rstN)       spReg <= SP_RESET;
    else if (spWrEn) spReg <= spWrData & ALIGN_MASK;
    else if (ramWe)  spReg <= spReg + WORD_STEP;
    else if (ramRe)  spReg <= spReg - WORD_STEP;
  end

  // limit: staged one cycle before reaching the comparator
  always_ff @(posedge clk) begin
    if (!rstN) begin
      limStage <= '1;
      limReg   <= ALIGN_MASK;
      limPend  <= 1'b0;
    end else begin
      limPend <= limWrEn;
      if (limWrEn) limStage <= limWrData & ALIGN_MASK;
      if (limPend) limReg   <= limStage;
    end
  end

  // captured request for replay and for the second frame word
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capKind <= K_NONE;
      capData <= '0;
      capPc   <= '0;
      capStat <= '0;
    end else if (st.capture) begin
      capKind <= st.kind;
      capData <= pushData;
      capPc   <= pcIn;
      capStat <= statusIn;
    end
  end

  assign spOut = spReg;

  // R2: a completed push advances the pointer by one word
  assert_push_post_inc_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ramWe && !spWrEn) |=> (spReg == $past(spReg) + WORD_STEP));

  // R2: a completed pop retreats the pointer by one word
  assert_pop_pre_dec_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ramRe && !spWrEn) |=> (spReg == $past(spReg) - WORD_STEP));

  // R4: no write lands above the limit
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (ramAddr <= limReg));

  // R5: no access lands below the floor
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ramWe || ramRe) |-> (ramAddr >= FLOOR_ADDR));

  // R4/R5: a trapped access leaves the pointer alone
  assert_trap_holds_sp_R4: assert property (@(posedge clk) disable iff (!rstN)
    (accTrap && !spWrEn) |=> (spReg == $past(spReg)));

  // R8: nothing reaches the RAM while a limit write is in flight
  assert_defer_after_limit_R8: assert property (@(posedge clk) disable iff (!rstN)
    limPend |-> !(ramWe || ramRe || accTrap));

endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import spu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PC_W   = 23,
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushReq,
  input  logic [DATA_W-1:0] pushData,
  input  logic              popReq,
  input  logic              callReq,
  input  logic              excReq,
  input  logic [PC_W-1:0]   pcIn,
  input  logic [STAT_W-1:0] statusIn,
  input  logic              spWrEn,
  input  logic [DATA_W-1:0] spWrData,
  input  logic              limWrEn,
  input  logic [DATA_W-1:0] limWrData,
  output logic [DATA_W-1:0] ramAddr,
  output logic              ramWe,
  output logic [DATA_W-1:0] ramWdata,
  output logic              ramRe,
  output logic [DATA_W-1:0] sp,
  output logic              busy,
  output logic              trapValid,
  output logic              trapCause
);

  strobes_t st;
  logic     limPend, accTrap;
  cause_t   cause;
  reqKind_t capKind;

  spu_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .pushReq (pushReq),
    .popReq  (popReq),
    .callReq (callReq),
    .excReq  (excReq),
    .limPend (limPend),
    .accTrap (accTrap),
    .capKind (capKind),
    .st      (st),
    .busy    (busy)
  );

  spu_datapath #(
    .DATA_W (DATA_W),
    .PC_W   (PC_W),
    .STAT_W (STAT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .pushData  (pushData),
    .pcIn      (pcIn),
    .statusIn  (statusIn),
    .spWrEn    (spWrEn),
    .spWrData  (spWrData),
    .limWrEn   (limWrEn),
    .limWrData (limWrData),
    .ramAddr   (ramAddr),
    .ramWe     (ramWe),
    .ramWdata  (ramWdata),
    .ramRe     (ramRe),
    .spOut     (sp),
    .limPend   (limPend),
    .accTrap   (accTrap),
    .trapCause (cause),
    .capKind   (capKind)
  );

  assign trapValid = accTrap;
  assign trapCause = cause;

  // R9: read and write strobes never coincide
  assert_single_access_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(ramWe && ramRe));

endmodule

// File: tb/tb_stack_ptr_unit.sv
module tb_stack_ptr_unit;

  logic        clk = 1'b0;
  logic        rstN;
  logic        pushReq, popReq, callReq, excReq;
  logic [15:0] pushData;
  logic [22:0] pcIn;
  logic [7:0]  statusIn;
  logic        spWrEn, limWrEn;
  logic [15:0] spWrData, limWrData;
  logic [15:0] ramAddr, ramWdata, sp;
  logic        ramWe, ramRe, busy, trapValid, trapCause;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  stack_ptr_unit dut (
    .clk(clk), .rstN(rstN),
    .pushReq(pushReq), .pushData(pushData), .popReq(popReq),
    .callReq(callReq), .excReq(excReq), .pcIn(pcIn), .statusIn(statusIn),
    .spWrEn(spWrEn), .spWrData(spWrData), .limWrEn(limWrEn), .limWrData(limWrData),
    .ramAddr(ramAddr), .ramWe(ramWe), .ramWdata(ramWdata), .ramRe(ramRe),
    .sp(sp), .busy(busy), .trapValid(trapValid), .trapCause(trapCause)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idleIns();
    pushReq = 0; popReq = 0; callReq = 0; excReq = 0;
    spWrEn = 0; limWrEn = 0;
  endtask

  // advance one cycle; inputs change only at the falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setSp(input logic [15:0] v);
    spWrEn = 1; spWrData = v; tick(); spWrEn = 0;
  endtask

  task automatic setLim(input logic [15:0] v);
    limWrEn = 1; limWrData = v; tick(); limWrEn = 0; tick();
  endtask

  task automatic testReset();
    #1;
    chk("R1", "sp", sp, 16'h0800);
    chk("R1", "busy", busy, 0);
    chk("R1", "ramWe", ramWe, 0);
    chk("R1", "trapValid", trapValid, 0);
  endtask

  task automatic testPushPop();
    setSp(16'h0900); setLim(16'h0FFE);
    pushReq = 1; pushData = 16'hA5A5; #1;
    chk("R2", "push we", ramWe, 1);
    chk("R2", "push addr", ramAddr, 16'h0900);
    chk("R2", "push data", ramWdata, 16'hA5A5);
    tick(); pushReq = 0; #1;
    chk("R2", "sp after push", sp, 16'h0902);
    popReq = 1; #1;
    chk("R2", "pop re", ramRe, 1);
    chk("R2", "pop addr", ramAddr, 16'h0900);
    chk("R2", "pop we", ramWe, 0);
    tick(); popReq = 0; #1;
    chk("R2", "sp after pop", sp, 16'h0900);
    pushReq = 1; popReq = 1; pushData = 16'h1111; #1;
    chk("R9", "push beats pop we", ramWe, 1);
    chk("R9", "push beats pop re", ramRe, 0);
    tick(); idleIns();
  endtask

  task automatic testLimit();
    setSp(16'h0A03); #1;
    chk("R3", "sp bit0 cleared", sp, 16'h0A02);
    setLim(16'h0A05);
    pushReq = 1; pushData = 16'h0001; #1;
    chk("R4", "below limit we", ramWe, 1);
    tick(); #1;
    chk("R4", "equal limit we", ramWe, 1);
    chk("R4", "equal limit addr", ramAddr, 16'h0A04);
    chk("R4", "equal limit trap", trapValid, 0);
    tick(); #1;
    chk("R4", "above limit we", ramWe, 0);
    chk("R4", "above limit trap", trapValid, 1);
    chk("R4", "above limit cause", trapCause, 0);
    tick(); pushReq = 0; #1;
    chk("R4", "sp held", sp, 16'h0A06);
    chk("R4", "trap is pulse", trapValid, 0);
  endtask

  task automatic testUnderflow();
    setLim(16'h0FFE); setSp(16'h0802);
    popReq = 1; #1;
    chk("R5", "pop to floor re", ramRe, 1);
    chk("R5", "pop to floor addr", ramAddr, 16'h0800);
    tick(); #1;
    chk("R5", "pop below floor re", ramRe, 0);
    chk("R5", "pop below floor trap", trapValid, 1);
    chk("R5", "pop below floor cause", trapCause, 1);
    tick(); popReq = 0; #1;
    chk("R5", "sp held", sp, 16'h0800);
    setLim(16'h0700); setSp(16'h07FE);
    pushReq = 1; #1;
    chk("R5", "push below floor we", ramWe, 0);
    chk("R5", "underflow wins cause", trapCause, 1);
    tick(); pushReq = 0; #1;
    chk("R5", "sp held after push", sp, 16'h07FE);
  endtask

  task automatic testCall();
    setLim(16'h0FFE); setSp(16'h0C00);
    callReq = 1; pcIn = 23'h5A_1234; #1;
    chk("R6", "lo we", ramWe, 1);
    chk("R6", "lo addr", ramAddr, 16'h0C00);
    chk("R6", "lo data", ramWdata, 16'h1234);
    tick(); callReq = 0; pushReq = 1; pushData = 16'hDEAD; pcIn = '0; #1;
    chk("R6", "busy on hi", busy, 1);
    chk("R6", "hi addr", ramAddr, 16'h0C02);
    chk("R6", "hi data", ramWdata, 16'h005A);
    tick(); pushReq = 0; #1;
    chk("R6", "sp after frame", sp, 16'h0C04);
    chk("R9", "push during busy ignored", ramWe, 0);
    chk("R6", "busy clear", busy, 0);
  endtask

  task automatic testExc();
    setSp(16'h0C40);
    excReq = 1; callReq = 1; pcIn = 23'h7F_ABCD; statusIn = 8'hC3; #1;
    chk("R7", "lo data", ramWdata, 16'hABCD);
    tick(); excReq = 0; callReq = 0; #1;
    chk("R7", "hi addr", ramAddr, 16'h0C42);
    chk("R9", "exception beats call", ramWdata, 16'hC37F);
    tick(); #1;
    chk("R7", "sp after frame", sp, 16'h0C44);
  endtask

  task automatic testLimStall();
    setSp(16'h0D00); setLim(16'h0FFE);
    limWrEn = 1; limWrData = 16'h0CFE; tick(); limWrEn = 0;
    pushReq = 1; pushData = 16'h7777; #1;
    chk("R8", "no access after limit write", ramWe, 0);
    chk("R8", "no trap after limit write", trapValid, 0);
    tick(); pushReq = 0; #1;
    chk("R8", "busy on replay", busy, 1);
    chk("R8", "replay uses new limit trap", trapValid, 1);
    chk("R8", "replay cause", trapCause, 0);
    chk("R8", "replay no write", ramWe, 0);
    tick(); #1;
    chk("R8", "sp held", sp, 16'h0D00);
    setLim(16'h0FFE);
    limWrEn = 1; limWrData = 16'h0D00; tick(); limWrEn = 0;
    pushReq = 1; pushData = 16'h4242; tick(); pushReq = 0; #1;
    chk("R8", "replayed push we", ramWe, 1);
    chk("R8", "replayed push data", ramWdata, 16'h4242);
    tick(); #1;
    chk("R8", "sp after replay", sp, 16'h0D02);
  endtask

  task automatic testFrameAbort();
    setLim(16'h0DFE); setSp(16'h0E00);
    callReq = 1; pcIn = 23'h01_0000; #1;
    chk("R10", "first word trap", trapValid, 1);
    chk("R10", "no write", ramWe, 0);
    tick(); callReq = 0; #1;
    chk("R10", "not busy", busy, 0);
    chk("R10", "no second write", ramWe, 0);
    chk("R10", "sp held", sp, 16'h0E00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idleIns();
    rstN = 0; pushData = '0; pcIn = '0; statusIn = '0;
    spWrData = '0; limWrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    @(negedge clk);
    testPushPop();
    testLimit();
    testUnderflow();
    testCall();
    testExc();
    testLimStall();
    testFrameAbort();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule